// File: doc/BRIEF.md
# Integer Execute Unit with Shifter

This block is the combinational integer execute stage of a 32-bit load/store processor. Each cycle it takes two register operands, a 16-bit immediate, a 5-bit shift count and a 5-bit operation code. It returns a 32-bit result and a signed-overflow flag in the same cycle. The pipeline around it registers the inputs and outputs, and it decides whether a flagged result is written back.

The operations are bitwise AND and OR, in register and immediate forms; logical left and right shifts; arithmetic right shift; upper-immediate load; add and subtract, each in a trapping and a non-trapping form; and less-than compares, signed and unsigned, in register and immediate forms. The immediate is extended differently for different operations:

- The bitwise immediate forms zero-extend it.
- The add and compare immediate forms sign-extend it.

A single adder serves add, subtract and both compares. A logarithmic shifter serves all three shift kinds.

The unit holds no state and has no clock. It has no state machine.

Top module: `int_exec_unit`

## Requirements
- R1: Operation codes on `op_sel`: 0 AND, 1 OR, 2 ANDI, 3 ORI, 4 SLL, 5 SRL, 6 SRA, 7 LUI, 8 ADD, 9 ADDU, 10 ADDI, 11 ADDIU, 12 SUB, 13 SUBU, 14 SLT, 15 SLTU, 16 SLTI, 17 SLTIU. AND (0) and OR (1) combine `opa` and `opb` bit by bit.
- R2: ANDI (2) and ORI (3) combine `opa` with the immediate zero-extended to 32 bits. As a result, ORI with 0xFFFF leaves bits 31:16 of `opa` unchanged.
- R3: SLL (4) and SRL (5) shift `opa` by `shamt` positions (0 to 31) and fill the vacated bits with zeros. A count of 0 returns `opa` unchanged.
- R4: SRA (6) shifts `opa` right by `shamt` positions and fills the vacated bits with copies of bit 31. For example, 0x92345678 shifted by 8 gives 0xFF923456.
- R5: LUI (7) returns the immediate in bits 31:16, with bits 15:0 cleared.
- R6: ADD, ADDU, SUB and SUBU return `opa`+`opb` or `opa`-`opb`, wrapped modulo 2^32.
- R7: ADDI and ADDIU return `opa` plus the sign-extended immediate, wrapped modulo 2^32.
- R8: `ovf` is 1 exactly when ADD, ADDI or SUB overflows as a signed operation. In that case the result is still the wrapped value. ADDU, ADDIU, SUBU and every other operation keep `ovf` at 0.
- R9: SLT and SLTU return 1 when `opa` is less than `opb`, compared as signed and as unsigned respectively, and 0 otherwise. Bits 31:1 of the result are always 0.
- R10: SLTI and SLTIU compare `opa` with the sign-extended immediate, as signed and as unsigned respectively. They return 1 or 0 in bit 0.
- R11: Operation codes 18 to 31 return result 0 with `ovf` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code (see R1) |
| opa | input | 32 | First register operand; the operand that is shifted |
| opb | input | 32 | Second register operand |
| imm | input | 16 | Immediate field |
| shamt | input | 5 | Shift count |
| result | output | 32 | Operation result |
| ovf | output | 1 | Signed overflow of a trapping add or subtract |

## Verification
Directed vectors cover the following patterns:

- Both ends of the shift count (0 and 31).
- A negative word under both right shifts, which separates zero fill from sign fill.
- Operands at the signed boundary (0x7FFFFFFF plus 1, 0x80000000 minus 1). These separate the trapping adds from the non-trapping adds, and show that the wrapped value is kept.
- Immediates with bit 15 set. These separate zero extension in the bitwise forms from sign extension in the add and compare forms.
- An all-ones operand compared against 1. This separates the signed compare from the unsigned compare.

Seeded random vectors over all codes, including the unused ones, then exercise the operand space at large. Edge words are mixed in often enough to keep hitting the carry and overflow boundaries.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;
    localparam int DATA_W = 32;
    localparam int IMM_W  = 16;
    localparam int OP_W   = 5;

    typedef enum logic [OP_W-1:0] {
        OP_AND   = 5'd0,
        OP_OR    = 5'd1,
        OP_ANDI  = 5'd2,
        OP_ORI   = 5'd3,
        OP_SLL   = 5'd4,
        OP_SRL   = 5'd5,
        OP_SRA   = 5'd6,
        OP_LUI   = 5'd7,
        OP_ADD   = 5'd8,
        OP_ADDU  = 5'd9,
        OP_ADDI  = 5'd10,
        OP_ADDIU = 5'd11,
        OP_SUB   = 5'd12,
        OP_SUBU  = 5'd13,
        OP_SLT   = 5'd14,
        OP_SLTU  = 5'd15,
        OP_SLTI  = 5'd16,
        OP_SLTIU = 5'd17
    } exec_op_e;
endpackage

// File: rtl/exec_bitwise.sv
module exec_bitwise #(
    parameter int W = 32
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         pick_or,
    output logic [W-1:0] dout
);
    // Each output bit depends only on the same bit of both inputs (R1).
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = pick_or ? (lhs[i] | rhs[i]) : (lhs[i] & rhs[i]);
    end
endmodule

// File: rtl/exec_shifter.sv
module exec_shifter #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    input  logic          go_left,
    input  logic          sign_fill,
    output logic [W-1:0]  dout
);
    logic [W-1:0] pre;
    logic [W-1:0] stg [0:SW];
    logic         fill;

    // Reverse the word on the way in for a left shift, so a single
    // right shifter serves all three shift kinds.
    for (genvar i = 0; i < W; i++) begin : g_rev_in
        assign pre[i] = go_left ? din[W-1-i] : din[i];
    end

    assign fill   = sign_fill & ~go_left & din[W-1];
    assign stg[0] = pre;

    // One stage per bit of the shift count.
    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int D = 1 << k;
        assign stg[k+1] = amt[k] ? {{D{fill}}, stg[k][W-1:D]} : stg[k];
    end

    // Reverse back on the way out for a left shift.
    for (genvar i = 0; i < W; i++) begin : g_rev_out
        assign dout[i] = go_left ? stg[SW][W-1-i] : stg[SW][i];
    end

    always_comb begin
        if (amt == '0) begin
            AST_SHIFT_ZERO_IDENT: assert (dout == din); // R3
        end
    end
endmodule

// File: rtl/exec_addsub.sv
module exec_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         do_sub,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         ovf_s
);
    logic [W-1:0] y_eff;

    assign y_eff          = do_sub ? ~y : y;
    assign {carry, sum}   = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, do_sub};
    assign ovf_s          = (x[W-1] == y_eff[W-1]) && (sum[W-1] != x[W-1]);

    always_comb begin
        if (do_sub && (x == y)) begin
            AST_SUB_SELF_ZERO: assert (sum == '0 && carry && !ovf_s); // R6
        end
    end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import int_exec_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int IW  = IMM_W,
    parameter int SHW = $clog2(DW)
) (
    input  logic [OP_W-1:0] op_sel,
    input  logic [DW-1:0]   opa,
    input  logic [DW-1:0]   opb,
    input  logic [IW-1:0]   imm,
    input  logic [SHW-1:0]  shamt,
    output logic [DW-1:0]   result,
    output logic            ovf
);
    localparam int EXT_W = DW - IW;

    exec_op_e     op;
    logic [DW-1:0] imm_zx, imm_sx;
    logic [DW-1:0] logic_rhs, logic_out;
    logic          logic_or;
    logic [DW-1:0] shift_out;
    logic          shift_left, shift_arith;
    logic [DW-1:0] arith_rhs, arith_sum;
    logic          arith_sub, arith_carry, arith_ovf;
    logic          lt_signed, lt_unsigned;

    assign op     = exec_op_e'(op_sel);
    assign imm_zx = {{EXT_W{1'b0}}, imm};
    assign imm_sx = {{EXT_W{imm[IW-1]}}, imm};

    // Bitwise path: the immediate forms use zero extension.
    assign logic_rhs = (op == OP_ANDI || op == OP_ORI) ? imm_zx : opb;
    assign logic_or  = (op == OP_OR || op == OP_ORI);

    exec_bitwise #(.W(DW)) u_bitwise (
        .lhs     (opa),
        .rhs     (logic_rhs),
        .pick_or (logic_or),
        .dout    (logic_out)
    );

    // Shift path.
    assign shift_left  = (op == OP_SLL);
    assign shift_arith = (op == OP_SRA);

    exec_shifter #(.W(DW), .SW(SHW)) u_shifter (
        .din       (opa),
        .amt       (shamt),
        .go_left   (shift_left),
        .sign_fill (shift_arith),
        .dout      (shift_out)
    );

    // Adder path: the add and compare immediate forms use sign extension.
    assign arith_rhs = (op == OP_ADDI || op == OP_ADDIU ||
                        op == OP_SLTI || op == OP_SLTIU) ? imm_sx : opb;
    assign arith_sub = (op == OP_SUB  || op == OP_SUBU  || op == OP_SLT ||
                        op == OP_SLTU || op == OP_SLTI  || op == OP_SLTIU);

    exec_addsub #(.W(DW)) u_addsub (
        .x      (opa),
        .y      (arith_rhs),
        .do_sub (arith_sub),
        .sum    (arith_sum),
        .carry  (arith_carry),
        .ovf_s  (arith_ovf)
    );

    assign lt_signed   = arith_sum[DW-1] ^ arith_ovf;
    assign lt_unsigned = ~arith_carry;

    always_comb begin
        result = '0;
        ovf    = 1'b0;
        unique case (op)
            OP_AND, OP_OR, OP_ANDI, OP_ORI: result = logic_out;
            OP_SLL, OP_SRL, OP_SRA:         result = shift_out;
            OP_LUI:                         result = {imm, {EXT_W{1'b0}}};
            OP_ADD, OP_ADDI, OP_SUB: begin
                result = arith_sum;
                ovf    = arith_ovf;
            end
            OP_ADDU, OP_ADDIU, OP_SUBU:     result = arith_sum;
            OP_SLT, OP_SLTI:                result = {{(DW-1){1'b0}}, lt_signed};
            OP_SLTU, OP_SLTIU:              result = {{(DW-1){1'b0}}, lt_unsigned};
            default: begin
                result = '0;
                ovf    = 1'b0;
            end
        endcase
    end

    always_comb begin
        if (ovf) begin
            AST_NO_OVERFLOW: assert (op == OP_ADD || op == OP_ADDI || op == OP_SUB); // R8
        end
        if (op == OP_SLT || op == OP_SLTU || op == OP_SLTI || op == OP_SLTIU) begin
            AST_CMP_BIT0_ONLY: assert (result[DW-1:1] == '0); // R9
        end
        if (op == OP_LUI) begin
            AST_LUI_LOW_CLEAR: assert (result[EXT_W-1:0] == '0); // R5
        end
        if (op == OP_ORI) begin
            AST_ORI_HIGH_KEEP: assert (result[DW-1:IW] == opa[DW-1:IW]); // R2
        end
    end
endmodule

// File: tb/int_exec_unit_tb_top.sv
module int_exec_unit_tb_top;
    logic        clk = 1'b0;
    logic [4:0]  op_sel;
    logic [31:0] opa, opb;
    logic [15:0] imm;
    logic [4:0]  shamt;
    logic [31:0] result;
    logic        ovf;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    int_exec_unit dut_i (
        .op_sel (op_sel),
        .opa    (opa),
        .opb    (opb),
        .imm    (imm),
        .shamt  (shamt),
        .result (result),
        .ovf    (ovf)
    );

    function automatic string req_of(input logic [4:0] op);
        case (op)
            5'd0, 5'd1:                         return "R1";
            5'd2, 5'd3:                         return "R2";
            5'd4, 5'd5:                         return "R3";
            5'd6:                               return "R4";
            5'd7:                               return "R5";
            5'd8, 5'd9, 5'd12, 5'd13:           return "R6";
            5'd10, 5'd11:                       return "R7";
            5'd14, 5'd15:                       return "R9";
            5'd16, 5'd17:                       return "R10";
            default:                            return "R11";
        endcase
    endfunction

    function automatic logic [32:0] ref_model(input logic [4:0] op, input logic [31:0] a,
                                              input logic [31:0] b, input logic [15:0] im,
                                              input logic [4:0] sh);
        logic [31:0] zx, sx, r;
        longint      wide;
        logic        of;
        zx = {16'h0, im};
        sx = {{16{im[15]}}, im};
        r  = 32'h0;
        of = 1'b0;
        case (op)
            5'd0:  r = a & b;
            5'd1:  r = a | b;
            5'd2:  r = a & zx;
            5'd3:  r = a | zx;
            5'd4:  r = a << sh;
            5'd5:  r = a >> sh;
            5'd6:  r = $unsigned($signed(a) >>> sh);
            5'd7:  r = {im, 16'h0};
            5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13: begin
                logic [31:0] rhs;
                rhs = (op == 5'd10 || op == 5'd11) ? sx : b;
                if (op == 5'd12 || op == 5'd13)
                    wide = longint'($signed(a)) - longint'($signed(rhs));
                else
                    wide = longint'($signed(a)) + longint'($signed(rhs));
                r  = wide[31:0];
                of = (op == 5'd8 || op == 5'd10 || op == 5'd12) &&
                     (wide > 64'sd2147483647 || wide < -64'sd2147483648);
            end
            5'd14: r = ($signed(a) < $signed(b))  ? 32'd1 : 32'd0;
            5'd15: r = (a < b)                    ? 32'd1 : 32'd0;
            5'd16: r = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
            5'd17: r = (a < sx)                   ? 32'd1 : 32'd0;
            default: r = 32'h0;
        endcase
        return {of, r};
    endfunction

    task automatic run_vec(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                           input logic [15:0] im, input logic [4:0] sh);
        logic [32:0] exp;
        @(negedge clk);
        op_sel = op; opa = a; opb = b; imm = im; shamt = sh;
        #2;
        exp = ref_model(op, a, b, im, sh);
        checks++;
        if (result !== exp[31:0]) begin
            errors++;
            $display("FAIL %s op=%0d result: actual=%h expected=%h", req_of(op), op, result, exp[31:0]);
        end
        checks++;
        if (ovf !== exp[32]) begin
            errors++;
            $display("FAIL R8 (%s) op=%0d ovf: actual=%b expected=%b", req_of(op), op, ovf, exp[32]);
        end
    endtask

    function automatic logic [31:0] pick_word();
        case ($urandom_range(0, 5))
            0: return 32'h7FFF_FFFF;
            1: return 32'h8000_0000;
            2: return 32'hFFFF_FFFF;
            3: return 32'h0000_0000;
            default: return $urandom();
        endcase
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        op_sel = 5'd0; opa = '0; opb = '0; imm = '0; shamt = '0;
        // Idle inputs: all-zero result (R1)
        run_vec(5'd0, 32'h0, 32'h0, 16'h0, 5'd0);
        // R1 mask
        run_vec(5'd0, 32'hB6A4_3D9A, 32'h0000_0FFF, 16'h0, 5'd0);
        run_vec(5'd1, 32'hF0F0_0000, 32'h0F0F_00FF, 16'h0, 5'd0);
        // R2 zero extension with bit 15 set
        run_vec(5'd3, 32'h1234_5678, 32'h0, 16'hFFFF, 5'd0);
        run_vec(5'd2, 32'hFFFF_FFFF, 32'h0, 16'h8001, 5'd0);
        // R3 shift count edges
        run_vec(5'd4, 32'h1234_5678, 32'h0, 16'h0, 5'd0);
        run_vec(5'd4, 32'h0000_0003, 32'h0, 16'h0, 5'd31);
        run_vec(5'd5, 32'h9234_5678, 32'h0, 16'h0, 5'd8);
        run_vec(5'd5, 32'h8000_0000, 32'h0, 16'h0, 5'd31);
        // R4 sign fill
        run_vec(5'd6, 32'h9234_5678, 32'h0, 16'h0, 5'd8);
        run_vec(5'd6, 32'h1234_5678, 32'h0, 16'h0, 5'd8);
        run_vec(5'd6, 32'h8000_0000, 32'h0, 16'h0, 5'd31);
        // R5
        run_vec(5'd7, 32'hFFFF_FFFF, 32'h0, 16'hABAB, 5'd0);
        // R6 / R8 boundary
        run_vec(5'd8,  32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0);
        run_vec(5'd9,  32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0);
        run_vec(5'd12, 32'h8000_0000, 32'h1, 16'h0, 5'd0);
        run_vec(5'd13, 32'h8000_0000, 32'h1, 16'h0, 5'd0);
        run_vec(5'd8,  32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0);
        // R7 sign-extended immediate
        run_vec(5'd10, 32'h0000_0010, 32'h0, 16'hFFCE, 5'd0);
        run_vec(5'd10, 32'h7FFF_FFF0, 32'h0, 16'h0010, 5'd0);
        run_vec(5'd11, 32'h7FFF_FFF0, 32'h0, 16'h0010, 5'd0);
        // R9 signed vs unsigned
        run_vec(5'd14, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0);
        run_vec(5'd15, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0);
        run_vec(5'd14, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 5'd0);
        // R10 immediate compares
        run_vec(5'd16, 32'hFFFF_FFFE, 32'h0, 16'hFFFF, 5'd0);
        run_vec(5'd17, 32'h0000_0005, 32'h0, 16'hFFFF, 5'd0);
        // R11 unused codes
        run_vec(5'd18, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd31);
        run_vec(5'd31, 32'h7FFF_FFFF, 32'h1, 16'h1, 5'd1);
        // Random mix over all codes
        for (int n = 0; n < 3000; n++) begin
            logic [4:0] op;
            op = (n % 16 == 15) ? 5'($urandom_range(18, 31)) : 5'($urandom_range(0, 17));
            run_vec(op, pick_word(), pick_word(), 16'($urandom()), 5'($urandom()));
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule